// File: doc/BRIEF.md
# SCSI Interrupt Status and Mask Unit

This block gathers the event strobes raised by a SCSI bus controller into eight sticky status bits. It combines them with an eight-bit enable mask to drive a single interrupt request. Several events are qualified before they can set their bit. A phase mismatch counts only when the phase sampled with a target REQ differs from the expected phase, and only in initiator mode. In target mode the same bit records an ATN assertion instead. The selection and reselection events count only when their response-enable inputs are set. A disconnect counts only in initiator mode, and only when it is flagged unexpected or the controller is in low-level mode.

Host software reaches the unit through a small register port with two locations. Address 0 holds the mask, which can be read and written. Address 1 holds the status, which is read, and written with ones to clear bits. The interrupt output is registered.

Top module: `scsi_irq_unit`

## Requirements
- R1: After reset the mask, the status, the read data and irq_o are all zero.
- R2: The status and mask bits are ordered phase-mismatch/attention (7), arbitration-and-selection complete (6), selected (5), reselected (4), gross error (3), unexpected disconnect (2), bus reset (1), parity error (0). A write with reg_addr=0 loads all eight mask bits. The read data returns the register chosen by reg_addr (0 selects the mask, 1 selects the status) one clock after reg_addr is presented.
- R3: irq_o is high one clock after any bit is set in both the status and the mask. It stays low whenever no such bit exists. A mask bit at 0 suppresses its condition.
- R4: In initiator mode (initiator_mode=1), status bit 7 sets when req_strobe is high and sampled_phase differs from expected_phase, and ATN has no effect. In target mode, bit 7 sets on atn_strobe, and REQ phase comparisons have no effect.
- R5: Bits 6, 3, 1 and 0 set directly on arb_sel_done, gross_err_evt, bus_reset_evt and parity_err_evt.
- R6: Bit 5 sets on selected_evt only while sel_resp_en=1. Bit 4 sets on reselected_evt only while resel_resp_en=1.
- R7: Bit 2 sets on disconnect_evt only in initiator mode. It also requires that disconnect_expected=0 or low_level_mode=1.
- R8: Status bits are sticky. A write with reg_addr=1 clears exactly the bits written as 1 and leaves the others unchanged.
- R9: If an event and a clear of the same bit occur in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = mask, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| initiator_mode | input | 1 | 1 = initiator, 0 = target |
| low_level_mode | input | 1 | Low-level operation: every disconnect is unexpected |
| sel_resp_en | input | 1 | Respond to selection |
| resel_resp_en | input | 1 | Respond to reselection |
| req_strobe | input | 1 | Target REQ sampled this cycle |
| sampled_phase | input | PHASE_W | Phase seen with REQ |
| expected_phase | input | PHASE_W | Phase expected by the sequencer |
| atn_strobe | input | 1 | Initiator asserted ATN |
| arb_sel_done | input | 1 | Arbitration and selection completed |
| selected_evt | input | 1 | Device was selected |
| reselected_evt | input | 1 | Device was reselected |
| gross_err_evt | input | 1 | Gross error detected |
| disconnect_evt | input | 1 | Target left the bus |
| disconnect_expected | input | 1 | Disconnect was anticipated |
| bus_reset_evt | input | 1 | Bus reset seen |
| parity_err_evt | input | 1 | Parity error seen |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The main sweep raises all 256 status patterns in a fully qualified configuration. Each pattern is read back and paired with several masks: all clear, all set, its complement, one walking bit and a scrambled value. Together these separate a correct AND-then-OR from a missing mask, an inverted mask and a wrong bit lane. Directed cases then toggle one qualifier at a time for the phase, selection and disconnect bits, to show that each gate blocks only its own bit. Partial clears and a clear colliding with an event confirm the sticky and priority rules.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
  localparam int NBITS   = 8;
  localparam int B_PHASE = 7;
  localparam int B_CMPL  = 6;
  localparam int B_SEL   = 5;
  localparam int B_RESEL = 4;
  localparam int B_GROSS = 3;
  localparam int B_UDISC = 2;
  localparam int B_RST   = 1;
  localparam int B_PAR   = 0;
  typedef logic [NBITS-1:0] irq_vec_t;
endpackage

// File: rtl/scsi_evt_qual.sv
module scsi_evt_qual
  import scsi_irq_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               initiator_mode,
  input  logic               low_level_mode,
  input  logic               sel_resp_en,
  input  logic               resel_resp_en,
  input  logic               req_strobe,
  input  logic [PHASE_W-1:0] sampled_phase,
  input  logic [PHASE_W-1:0] expected_phase,
  input  logic               atn_strobe,
  input  logic               arb_sel_done,
  input  logic               selected_evt,
  input  logic               reselected_evt,
  input  logic               gross_err_evt,
  input  logic               disconnect_evt,
  input  logic               disconnect_expected,
  input  logic               bus_reset_evt,
  input  logic               parity_err_evt,
  output irq_vec_t           evt_o
);
  logic phase_miss;
  assign phase_miss = req_strobe && (sampled_phase != expected_phase);

  always_comb begin
    evt_o          = '0;
    evt_o[B_PHASE] = initiator_mode ? phase_miss : atn_strobe;
    evt_o[B_CMPL]  = arb_sel_done;
    evt_o[B_SEL]   = selected_evt && sel_resp_en;
    evt_o[B_RESEL] = reselected_evt && resel_resp_en;
    evt_o[B_GROSS] = gross_err_evt;
    evt_o[B_UDISC] = initiator_mode && disconnect_evt &&
                     (low_level_mode || !disconnect_expected);
    evt_o[B_RST]   = bus_reset_evt;
    evt_o[B_PAR]   = parity_err_evt;
  end
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
  import scsi_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_vec_t evt_i,
  input  irq_vec_t clr_i,
  output irq_vec_t status_o
);
  irq_vec_t status_q;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           status_q[i] <= 1'b0;
      else if (evt_i[i]) status_q[i] <= 1'b1;
      else if (clr_i[i]) status_q[i] <= 1'b0;
    end
  end

  assign status_o = status_q;

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R9
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~evt_i)) |=> ((status_q & $past(clr_i & ~evt_i)) == '0)); // R8
  AST_STICKY_ONLY_ON_EVT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0)); // R8
endmodule

// File: rtl/scsi_irq_mask.sv
module scsi_irq_mask
  import scsi_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     mask_wr,
  input  irq_vec_t wdata,
  input  irq_vec_t status_i,
  output irq_vec_t mask_o,
  output logic     irq_o
);
  irq_vec_t mask_q;
  logic     irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= wdata;
      irq_q <= |(status_i & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_q); // R3
  AST_NO_STATUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (status_i == '0) |=> !irq_q); // R3
  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> (mask_q == $past(wdata))); // R2
endmodule

// File: rtl/scsi_irq_unit.sv
module scsi_irq_unit
  import scsi_irq_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               initiator_mode,
  input  logic               low_level_mode,
  input  logic               sel_resp_en,
  input  logic               resel_resp_en,
  input  logic               req_strobe,
  input  logic [PHASE_W-1:0] sampled_phase,
  input  logic [PHASE_W-1:0] expected_phase,
  input  logic               atn_strobe,
  input  logic               arb_sel_done,
  input  logic               selected_evt,
  input  logic               reselected_evt,
  input  logic               gross_err_evt,
  input  logic               disconnect_evt,
  input  logic               disconnect_expected,
  input  logic               bus_reset_evt,
  input  logic               parity_err_evt,
  output logic               irq_o
);
  irq_vec_t evt, clr, status, mask;
  logic [7:0] rdata_q;

  scsi_evt_qual #(.PHASE_W(PHASE_W)) u_qual (
    .initiator_mode(initiator_mode), .low_level_mode(low_level_mode),
    .sel_resp_en(sel_resp_en), .resel_resp_en(resel_resp_en),
    .req_strobe(req_strobe), .sampled_phase(sampled_phase),
    .expected_phase(expected_phase), .atn_strobe(atn_strobe),
    .arb_sel_done(arb_sel_done), .selected_evt(selected_evt),
    .reselected_evt(reselected_evt), .gross_err_evt(gross_err_evt),
    .disconnect_evt(disconnect_evt), .disconnect_expected(disconnect_expected),
    .bus_reset_evt(bus_reset_evt), .parity_err_evt(parity_err_evt),
    .evt_o(evt)
  );

  assign clr = (reg_wr && reg_addr) ? reg_wdata : '0;

  scsi_irq_status u_status (
    .clk(clk), .rst(rst), .evt_i(evt), .clr_i(clr), .status_o(status)
  );

  scsi_irq_mask u_mask (
    .clk(clk), .rst(rst), .mask_wr(reg_wr && !reg_addr), .wdata(reg_wdata),
    .status_i(status), .mask_o(mask), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= reg_addr ? status : mask;
  end
  assign reg_rdata = rdata_q;

  AST_UDISC_TARGET_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!initiator_mode && !status[B_UDISC]) |=> !status[B_UDISC]); // R7
  AST_SEL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (!sel_resp_en && !status[B_SEL]) |=> !status[B_SEL]); // R6
  AST_RESEL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (!resel_resp_en && !status[B_RESEL]) |=> !status[B_RESEL]); // R6
endmodule

// File: tb/tb_scsi_irq_unit.sv
`timescale 1ns/1ps
module tb_scsi_irq_unit;
  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic initiator_mode = 1, low_level_mode = 0, sel_resp_en = 1, resel_resp_en = 1;
  logic req_strobe = 0, atn_strobe = 0, arb_sel_done = 0, selected_evt = 0;
  logic reselected_evt = 0, gross_err_evt = 0, disconnect_evt = 0;
  logic disconnect_expected = 0, bus_reset_evt = 0, parity_err_evt = 0;
  logic [2:0] sampled_phase = 3'd1, expected_phase = 3'd2;
  logic irq_o;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  scsi_irq_unit dut (.*);

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic zero_evts;
    req_strobe = 0; atn_strobe = 0; arb_sel_done = 0; selected_evt = 0;
    reselected_evt = 0; gross_err_evt = 0; disconnect_evt = 0;
    bus_reset_evt = 0; parity_err_evt = 0;
  endtask

  task automatic fire; tick; zero_evts; endtask

  task automatic full_qual;
    initiator_mode = 1; low_level_mode = 0; sel_resp_en = 1; resel_resp_en = 1;
    disconnect_expected = 0; sampled_phase = 3'd1; expected_phase = 3'd2;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick; reg_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    reg_addr = a; tick; v = reg_rdata;
  endtask

  task automatic raise(input logic [7:0] s);
    full_qual;
    req_strobe = s[7]; arb_sel_done = s[6]; selected_evt = s[5];
    reselected_evt = s[4]; gross_err_evt = s[3]; disconnect_evt = s[2];
    bus_reset_evt = s[1]; parity_err_evt = s[0];
    fire;
  endtask

  task automatic one_case(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    fire; rd(1, v); chk(tag, v, exp); wr(1, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] ml [5];
    repeat (3) tick;
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 rdata", reg_rdata, 8'h00);
    rst = 0;
    rd(0, v); chk("R1 mask", v, 8'h00);
    rd(1, v); chk("R1 status", v, 8'h00);

    wr(0, 8'hA5); rd(0, v); chk("R2 mask readback", v, 8'hA5);
    wr(0, 8'h00);

    // R3 timing: irq one clock after status
    wr(0, 8'h01); raise(8'h01);
    chk("R3 irq not yet", {7'd0, irq_o}, 8'h00);
    tick; chk("R3 irq after one clock", {7'd0, irq_o}, 8'h01);
    wr(1, 8'hFF); tick; tick;
    chk("R3 irq drops", {7'd0, irq_o}, 8'h00);

    // Sweep: all status patterns against several masks (R2 R3 R5 R8)
    for (int s = 0; s < 256; s++) begin
      raise(s[7:0]);
      rd(1, v); chk("R2 R5 status pattern", v, s[7:0]);
      ml[0] = 8'h00; ml[1] = 8'hFF; ml[2] = ~s[7:0];
      ml[3] = 8'h01 << (s % 8); ml[4] = s[7:0] ^ 8'h5A;
      for (int k = 0; k < 5; k++) begin
        wr(0, ml[k]); tick;
        chk("R3 irq vs mask", {7'd0, irq_o}, {7'd0, |(s[7:0] & ml[k])});
      end
      wr(1, 8'hFF);
    end
    wr(0, 8'h00);

    // R4 phase / attention
    full_qual; req_strobe = 1; sampled_phase = 3'd2; one_case("R4 init phase match", 8'h00);
    full_qual; req_strobe = 1; one_case("R4 init phase mismatch", 8'h80);
    full_qual; atn_strobe = 1; one_case("R4 init ATN ignored", 8'h00);
    full_qual; initiator_mode = 0; atn_strobe = 1; one_case("R4 target ATN", 8'h80);
    full_qual; initiator_mode = 0; req_strobe = 1; one_case("R4 target mismatch ignored", 8'h00);

    // R6 selection gates
    full_qual; sel_resp_en = 0; selected_evt = 1; one_case("R6 sel disabled", 8'h00);
    full_qual; selected_evt = 1; one_case("R6 sel enabled", 8'h20);
    full_qual; resel_resp_en = 0; reselected_evt = 1; one_case("R6 resel disabled", 8'h00);
    full_qual; reselected_evt = 1; one_case("R6 resel enabled", 8'h10);

    // R7 disconnect
    full_qual; initiator_mode = 0; disconnect_evt = 1; one_case("R7 target disc", 8'h00);
    full_qual; disconnect_expected = 1; disconnect_evt = 1; one_case("R7 expected disc", 8'h00);
    full_qual; disconnect_expected = 1; low_level_mode = 1; disconnect_evt = 1;
    one_case("R7 low-level disc", 8'h04);
    full_qual; disconnect_evt = 1; one_case("R7 unexpected disc", 8'h04);

    // R8 partial clear and stickiness
    raise(8'hFF); tick; tick;
    rd(1, v); chk("R8 sticky", v, 8'hFF);
    wr(1, 8'h0F); rd(1, v); chk("R8 partial clear", v, 8'hF0);
    wr(1, 8'hFF);

    // R9 event and clear together
    full_qual; parity_err_evt = 1; gross_err_evt = 1;
    reg_wr = 1; reg_addr = 1; reg_wdata = 8'hFF; tick; reg_wr = 0; zero_evts;
    rd(1, v); chk("R9 event beats clear", v, 8'h09);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule